// File: doc/BRIEF.md
# Second-Order Pulse-Density Audio Modulator

This block turns signed 16-bit PCM audio into a single-bit pulse-density stream. An FPGA pin carries the stream to an external RC low-pass filter, which recovers the analog signal. Inside, two accumulators form a second-order error-feedback loop. A sign test on the second accumulator picks the output bit. That bit then selects a fixed positive or negative reference, which each stage subtracts before it accumulates.

Each stage's new value passes through a saturating clamp. The clamp magnitude is a run-time input, so the loop state cannot run away when the input sits near full scale. A value of about 60% of full scale (19660) is the intended setting. The modulator advances one step on each cycle where `step_en` is high, so the rate of that enable sets the oversampling rate. Every `OSR` steps make one sample period. A valid/ready handshake at the start of each period delivers a fresh sample, and the loop then uses that sample for every step of the period.

A two-state controller tracks the period. **S_FETCH** is the state in which the next step opens a period and may take a sample. The transition *fetch→run* happens on that step when `OSR` > 1. **S_RUN** counts the remaining steps. The transition *run→fetch* happens on the step that ends the period. Reset enters S_FETCH.

Top module: `sdm2_dac`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `bit_out` and `sat_pulse` are 0. Reset clears both accumulators and the held sample to zero.
- R2: `smp_ready` is high only in a cycle where `step_en` is high and that step opens a sample period. The first step after reset opens a period, and every `OSR`-th step after that opens another.
- R3: A sample is taken when `smp_valid` and `smp_ready` are both high. It is used from that step on and held for all `OSR` steps of the period. `smp_data` is ignored at any other time.
- R4: If `smp_valid` is low at a period-opening step, the previously held sample is used for the whole period. The held sample is zero after reset.
- R5: On each step, fb = +32767 when `bit_out` is 1 and -32767 when it is 0. The updates are a1 ← clamp(a1 + x − fb), then a2 ← clamp(a2 + a1new − fb). The new `bit_out` is 1 when a2new ≥ 0. The new bit appears in the cycle after the step edge.
- R6: In a cycle where `step_en` is low, the loop state, `bit_out` and the period position do not change.
- R7: When `clamp_lim` = L is non-zero, each accumulator's new value is limited to the range [−L, +L].
- R8: When `clamp_lim` is 0, the accumulators are limited only by their natural signed width: [−2^23, 2^23−1] at the default width of 24.
- R9: `sat_pulse` is high for the one cycle after a step in which either stage was clamped. It is low after any step with no clamp and after any cycle with no step.
- R10: Over many steps with a constant input x and no limiting, the fraction of ones in `bit_out` is close to (x/32767 + 1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Oversampling tick; one modulator step per high cycle |
| smp_valid | input | 1 | A new PCM sample is offered |
| smp_data | input | 16 | Signed two's-complement PCM sample |
| smp_ready | output | 1 | Sample accepted on this cycle when `smp_valid` is high |
| clamp_lim | input | 23 | Clamp magnitude for the accumulators; 0 selects the natural width |
| bit_out | output | 1 | Pulse-density output bit |
| sat_pulse | output | 1 | One-cycle flag: a stage was clamped on the last step |

## Verification
The bench runs a cycle-exact model of the loop next to the design and goes after these corner cases:
- **Full-scale input with a 60% clamp.** A design that clamps against the wrong bound, or clamps only one stage, drifts away from the model's bit stream and its count of clamp events.
- **A zero clamp value.** A design that treats 0 as a real limit would pin both accumulators at zero and stall the output.
- **Period boundaries.** A missing sample at a period start must replay the held value, and data that changes mid-period must be ignored. An off-by-one in the step counter, or latching data outside the handshake, shows up as a shifted bit stream.
- **Reset in mid-run.** A stale accumulator after reset shows up as a shifted bit stream.
- **Idle cycles between steps.** A `sat_pulse` that is not cleared, or an output that moves without a step, shows up in these cycles.

// File: rtl/sdm2_pkg.sv
`timescale 1ns/1ps
package sdm2_pkg;
    // Position of the modulator within one sample period
    typedef enum logic {
        S_FETCH = 1'b0,
        S_RUN   = 1'b1
    } phase_e;
endpackage

// File: rtl/sdm2_phase_ctl.sv
`timescale 1ns/1ps
module sdm2_phase_ctl
    import sdm2_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int OSR  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic                   smp_valid,
    input  logic signed [IN_W-1:0] smp_data,
    output logic                   smp_ready,
    output logic signed [IN_W-1:0] x_cur
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    phase_e                 state, state_nx;
    logic [CW-1:0]          step_cnt;
    logic signed [IN_W-1:0] x_hold;
    logic                   take;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_FETCH;
            step_cnt <= '0;
            x_hold   <= '0;
        end else begin
            state <= state_nx;
            if (step_en)
                step_cnt <= (state == S_FETCH) ? CW'(1) : step_cnt + CW'(1);
            if (take)
                x_hold <= smp_data;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH: if (step_en && OSR > 1)          state_nx = S_RUN;
            S_RUN:   if (step_en && step_cnt == LAST) state_nx = S_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        smp_ready = step_en && (state == S_FETCH);
        take      = smp_ready && smp_valid;
        x_cur     = take ? smp_data : x_hold;
    end

    AST_RUN_NEEDS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (state == S_RUN && !step_en) |=> (state == S_RUN)) else $error("run left without step"); // R6
endmodule

// File: rtl/sdm2_integ.sv
`timescale 1ns/1ps
module sdm2_integ #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    input  logic signed [ACC_W-1:0] fb,
    input  logic [ACC_W-2:0]        lim,
    output logic signed [ACC_W-1:0] acc_d,
    output logic                    clamped
);
    localparam int EW = ACC_W + 2;
    localparam logic signed [EW-1:0] NAT_HI = EW'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [EW-1:0] NAT_LO = -NAT_HI - EW'(1);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [EW-1:0]    sum, hi, lo;

    always_comb begin
        sum = EW'(acc_q) + EW'(din) - EW'(fb);
        if (lim == '0) begin
            hi = NAT_HI;
            lo = NAT_LO;
        end else begin
            hi = $signed({3'b000, lim});
            lo = -hi;
        end
        clamped = (sum > hi) || (sum < lo);
        if (sum > hi)      acc_d = hi[ACC_W-1:0];
        else if (sum < lo) acc_d = lo[ACC_W-1:0];
        else               acc_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= acc_d;
    end

    AST_ACC_IN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (en && lim != '0) |=> (acc_q <= $signed({1'b0, $past(lim)}) &&
                               acc_q >= -$signed({1'b0, $past(lim)}))) else $error("acc outside limit"); // R7
endmodule

// File: rtl/sdm2_dac.sv
`timescale 1ns/1ps
module sdm2_dac #(
    parameter int IN_W    = 16,
    parameter int ACC_W   = 24,
    parameter int OSR     = 8,
    parameter int N_STAGE = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic                   smp_valid,
    input  logic signed [IN_W-1:0] smp_data,
    output logic                   smp_ready,
    input  logic [ACC_W-2:0]       clamp_lim,
    output logic                   bit_out,
    output logic                   sat_pulse
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic signed [ACC_W-1:0] REF_P = ACC_W'((64'sd1 <<< (IN_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] REF_N = -REF_P;

    logic signed [IN_W-1:0]  x_cur;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] st_in [N_STAGE];
    logic signed [ACC_W-1:0] st_d  [N_STAGE];
    logic [N_STAGE-1:0]      st_clamp;

    sdm2_phase_ctl #(.IN_W(IN_W), .OSR(OSR)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .x_cur     (x_cur)
    );

    assign fb = bit_out ? REF_P : REF_N;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign st_in[g] = ACC_W'(x_cur);
        end else begin : g_tail
            assign st_in[g] = st_d[g-1];
        end
        sdm2_integ #(.ACC_W(ACC_W)) u_integ (
            .clk     (clk),
            .rst     (rst),
            .en      (step_en),
            .din     (st_in[g]),
            .fb      (fb),
            .lim     (clamp_lim),
            .acc_d   (st_d[g]),
            .clamped (st_clamp[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out   <= 1'b0;
            sat_pulse <= 1'b0;
        end else begin
            sat_pulse <= step_en && (|st_clamp);
            if (step_en)
                bit_out <= ~st_d[N_STAGE-1][ACC_W-1];
        end
    end

    // period checker: steps seen since the last accepted fetch slot
    logic [CW-1:0] chk_steps;
    always_ff @(posedge clk) begin
        if (rst)          chk_steps <= CW'(OSR - 1);
        else if (step_en) chk_steps <= smp_ready ? '0 : chk_steps + CW'(1);
    end

    AST_READY_ON_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (step_en && chk_steps == CW'(OSR - 1)) |-> smp_ready) else $error("ready missing"); // R2
    AST_READY_ONLY_PERIOD: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> (step_en && chk_steps == CW'(OSR - 1))) else $error("ready misplaced"); // R2
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(bit_out)) else $error("bit moved without step"); // R6
    AST_SAT_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> !sat_pulse) else $error("sat pulse without step"); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bit_out && !sat_pulse)) else $error("reset state"); // R1
endmodule

// File: tb/test_sdm2_dac.sv
`timescale 1ns/1ps
module test_sdm2_dac;
    localparam int OSR = 8;
    localparam longint REF = 32767;
    localparam longint NAT_HI = 8388607;
    localparam longint NAT_LO = -8388608;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               step_en = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic               smp_ready;
    logic [22:0]        clamp_lim = '0;
    logic               bit_out;
    logic               sat_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    longint m_a1, m_a2, m_x;
    bit     m_bit, m_sat;
    int     m_phase;
    int     ones;

    always #4 clk = ~clk;

    sdm2_dac i_sdm2_dac (
        .clk(clk), .rst(rst), .step_en(step_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_ready(smp_ready), .clamp_lim(clamp_lim),
        .bit_out(bit_out), .sat_pulse(sat_pulse)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clampm(input longint v, inout bit hit);
        longint hi, lo;
        hi = (clamp_lim == 0) ? NAT_HI : longint'(clamp_lim);
        lo = (clamp_lim == 0) ? NAT_LO : -longint'(clamp_lim);
        if (v > hi) begin hit = 1; return hi; end
        if (v < lo) begin hit = 1; return lo; end
        return v;
    endfunction

    task automatic model_reset();
        m_a1 = 0; m_a2 = 0; m_x = 0; m_bit = 0; m_sat = 0; m_phase = 0;
    endtask

    // one modulator step preceded by one idle cycle
    task automatic do_step(input bit v, input logic signed [15:0] d, input string req);
        bit     prev_bit, hit;
        longint fbm;
        @(negedge clk);
        prev_bit = bit_out;
        // idle cycle before this edge: pulse cleared, bit held (R9, R6)
        check(sat_pulse == 1'b0, "R9 idle", sat_pulse, 0);
        smp_valid = v;
        smp_data  = d;
        step_en   = 1'b1;
        #1;
        check(smp_ready == (m_phase == 0), "R2 ready", smp_ready, (m_phase == 0));
        if (m_phase == 0 && v) m_x = d;
        hit  = 0;
        fbm  = m_bit ? REF : -REF;
        m_a1 = clampm(m_a1 + m_x - fbm, hit);
        m_a2 = clampm(m_a2 + m_a1 - fbm, hit);
        m_bit = (m_a2 >= 0);
        m_sat = hit;
        m_phase = (m_phase + 1) % OSR;
        @(negedge clk);
        step_en   = 1'b0;
        smp_valid = 1'b0;
        smp_data  = 16'sh5a5a; // junk, must be ignored (R3)
        check(bit_out == m_bit, req, bit_out, m_bit);
        check(sat_pulse == m_sat, "R9 pulse", sat_pulse, m_sat);
        if (bit_out) ones++;
        if (prev_bit !== bit_out && m_bit == prev_bit)
            check(0, "R6 hold", bit_out, prev_bit);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; step_en = 1'b0; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(bit_out == 0 && sat_pulse == 0, "R1 in reset", {bit_out, sat_pulse}, 0);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check(bit_out == 0 && sat_pulse == 0, "R1 after reset", {bit_out, sat_pulse}, 0);
        check(smp_ready == 0, "R2 no step", smp_ready, 0);
    endtask

    // run whole periods at constant input and check density (R10)
    task automatic t_density(input logic signed [15:0] x, input int periods, input string req);
        int lo_lim, hi_lim, total;
        clamp_lim = '0;
        apply_reset();
        ones = 0;
        for (int p = 0; p < periods; p++)
            for (int s = 0; s < OSR; s++)
                do_step(1'b1, x, "R5 stream");
        total  = periods * OSR;
        lo_lim = int'((real'(x) / 32767.0 + 1.0) / 2.0 * total) - 6;
        hi_lim = lo_lim + 12;
        check(ones >= lo_lim && ones <= hi_lim, req, ones, lo_lim + 6);
    endtask

    task automatic t_limited();
        int sats;
        apply_reset();
        clamp_lim = 23'd19660;
        sats = 0;
        for (int i = 0; i < 12 * OSR; i++) begin
            do_step(1'b1, 16'sd32767, "R7 stream");
            if (sat_pulse) sats++;
        end
        check(sats > 0, "R7 clamp seen", sats, 1);
        clamp_lim = '0;
    endtask

    task automatic t_natural();
        apply_reset();
        clamp_lim = '0;
        for (int i = 0; i < 12 * OSR; i++)
            do_step(1'b1, -16'sd32768, "R8 stream");
    endtask

    task automatic t_underrun();
        apply_reset();
        // first period with no sample: held value is zero (R4)
        for (int s = 0; s < OSR; s++) do_step(1'b0, 16'sd20000, "R4 zero hold");
        for (int s = 0; s < OSR; s++) do_step(s == 0, 16'sd12000, "R3 latch");
        // missing sample: 12000 must be replayed (R4)
        for (int s = 0; s < 3 * OSR; s++) do_step(1'b0, -16'sd30000, "R4 replay");
        // valid high mid-period is ignored (R3)
        for (int s = 0; s < OSR; s++) do_step(1'b1, (s == 0) ? -16'sd8000 : 16'sd31000, "R3 ignore");
    endtask

    task automatic t_mid_reset();
        clamp_lim = 23'd19660;
        for (int s = 0; s < 5; s++) do_step(1'b1, 16'sd25000, "R5 pre-reset");
        apply_reset();
        for (int s = 0; s < 3 * OSR; s++) do_step(1'b1, -16'sd5000, "R1 restart");
        clamp_lim = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        apply_reset();
        t_density(16'sd0, 16, "R10 zero");
        t_density(16'sd16384, 16, "R10 positive");
        t_density(-16'sd16384, 16, "R10 negative");
        t_limited();
        t_natural();
        t_underrun();
        t_mid_reset();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule